// File: doc/BRIEF.md
# PSI5 Asynchronous Frame Transmitter

This block turns 10-bit sensor samples into periodic PSI5 asynchronous-mode frames on one modulation control line. The line drives an external current modulator. A frame has 13 bit cells: two start cells of logic 0, then the ten data bits least significant first, then an even parity bit. Each cell is Manchester coded. A 0 is sent as low then high, and a 1 as high then low. Between frames the line rests low. The receiver sends no trigger. Frames start on an internal period that begins when the block is enabled.

A sample is captured into a holding register whenever its valid strobe is high. At each frame start, the transmitter copies either the holding register or a sample presented in that same cycle into its frame shifter. Later samples therefore wait for the next frame. A clock divider sets the half-cell length. The default is 64 clocks at 16 MHz, which gives the 8 µs cell of 125 kbit/s. A second counter sets the frame period, with a default of 228 µs.

The controller has four states, and `en` low forces the state machine to OFF from any state:

| From | Condition | To |
|------|-----------|----|
| OFF | period counter at zero (the first clock with `en` high) | HALF1 |
| HALF1 (first half of a cell) | half-cell count complete | HALF2 |
| HALF2 (second half of a cell) | half-cell count complete and cells remain | HALF1 |
| HALF2 | half-cell count complete on the last cell | GAP |
| GAP (waiting for the next period) | period counter at zero | HALF1 |

Top module: `sensor_frame_tx`

## Requirements
- R1: While `rst_n` is low, `mod_out` and `busy` are 0. The holding register resets to 0, so a frame sent before any valid sample carries data 0.
- R2: The first two cells of every frame are logic 0 cells.
- R3: Each cell lasts 2·HALF_CLKS clocks. For a cell of value b, `mod_out` equals b for the first HALF_CLKS clocks and ~b for the next HALF_CLKS clocks.
- R4: Cells 2 to 11 carry data bits 0 to 9 in that order, least significant first.
- R5: Cell 12 is the parity bit. It makes the ten data bits plus parity hold an even number of ones.
- R6: `busy` is 1 for exactly 26·HALF_CLKS clocks per frame, starting the clock after the frame-start edge.
- R7: While `en` stays high, frames start every PERIOD_CLKS clocks. Between frames `mod_out` and `busy` are 0. PERIOD_CLKS must exceed 26·HALF_CLKS.
- R8: `sample_data` is captured only in cycles where `sample_valid` is 1, and changes without the strobe are ignored. A strobe at the frame-start edge goes into that frame.
- R9: The frame content is fixed at the frame-start edge. A sample strobed mid-frame appears only in the next frame.
- R10: While `en` is 0, `mod_out` and `busy` are 0 in the same cycle. A frame in progress is abandoned. The first clock edge with `en` high starts a new frame from the first start cell and restarts the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Transmit enable |
| sample_data | input | DATA_W | Sensor sample |
| sample_valid | input | 1 | Capture strobe for `sample_data` |
| mod_out | output | 1 | Manchester modulation control line |
| busy | output | 1 | High while a frame is on the line |

## Verification
Call the frame-start edge E0. It is the first rising edge with `en` high, or the edge that ends a period. The cell k, half h level is due in cycle 2k·HALF_CLKS + h·HALF_CLKS after E0, and the next frame is due PERIOD_CLKS cycles after E0. The disable response is combinational, so it is due in the same cycle `en` falls. The bench drives inputs and samples outputs on falling edges and keeps a cycle index from E0. It compares every cycle of each period against a level computed from the data word, the parity and the requirements. Strobes that are to land in the next frame are applied at a fixed mid-frame index.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_HALF1 = 2'd1,
        ST_HALF2 = 2'd2,
        ST_GAP   = 2'd3
    } tx_state_t;

    // Number of leading logic-0 cells in a frame
    localparam int PRE_CELLS = 2;

    // Total cells: start cells, data cells, one parity cell
    function automatic int frame_cells(input int data_w);
        return PRE_CELLS + data_w + 1;
    endfunction

endpackage

// File: rtl/sfx_period_timer.sv
module sfx_period_timer #(
    parameter int PERIOD_CLKS = 3648
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic at_zero
);
    localparam int CW = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1;

    logic [CW-1:0] cnt_q;

    // Held at zero while stopped, so a restart begins a fresh period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(PERIOD_CLKS - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_zero = (cnt_q == '0);

endmodule

// File: rtl/sfx_half_timer.sv
module sfx_half_timer #(
    parameter int HALF_CLKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic last
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(HALF_CLKS - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = active && (cnt_q == CW'(HALF_CLKS - 1));

endmodule

// File: rtl/sfx_frame_reg.sv
module sfx_frame_reg #(
    parameter int DATA_W = 10,
    localparam int FRAME_W = sfx_pkg::frame_cells(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               shift,
    input  logic [DATA_W-1:0]  word,
    output logic               cur_bit,
    output logic               last_cell,
    output logic [FRAME_W-1:0] frame_q
);
    localparam int PRE = sfx_pkg::PRE_CELLS;
    localparam int IW  = $clog2(FRAME_W);

    logic [FRAME_W-1:0] frame_d;
    logic [IW-1:0]      idx_q;

    // Assemble the cell sequence, cell 0 in bit 0
    for (genvar g = 0; g < FRAME_W; g++) begin : g_cell
        if (g < PRE) begin : g_pre
            assign frame_d[g] = 1'b0;
        end else if (g < PRE + DATA_W) begin : g_dat
            assign frame_d[g] = word[g - PRE];
        end else begin : g_par
            assign frame_d[g] = ^word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            idx_q   <= '0;
        end else if (load) begin
            frame_q <= frame_d;
            idx_q   <= '0;
        end else if (shift) begin
            frame_q <= frame_q >> 1;
            idx_q   <= idx_q + 1'b1;
        end
    end

    assign cur_bit   = frame_q[0];
    assign last_cell = (idx_q == IW'(FRAME_W - 1));

endmodule

// File: rtl/sensor_frame_tx.sv
module sensor_frame_tx #(
    parameter int DATA_W      = 10,
    parameter int HALF_CLKS   = 64,
    parameter int PERIOD_CLKS = 3648
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] sample_data,
    input  logic              sample_valid,
    output logic              mod_out,
    output logic              busy
);
    import sfx_pkg::*;

    localparam int FRAME_W = frame_cells(DATA_W);

    tx_state_t          state, state_d;
    logic               period_zero;
    logic               half_last;
    logic               cell_last;
    logic               cur_bit;
    logic               start;
    logic               shift;
    logic               in_cell;
    logic [DATA_W-1:0]  held_q;
    logic [DATA_W-1:0]  load_word;
    logic [FRAME_W-1:0] frame_q;

    // Sample holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (sample_valid) begin
            held_q <= sample_data;
        end
    end

    assign load_word = sample_valid ? sample_data : held_q;

    assign in_cell = en && (state == ST_HALF1 || state == ST_HALF2);
    assign start   = en && period_zero && (state == ST_OFF || state == ST_GAP);
    assign shift   = en && (state == ST_HALF2) && half_last;

    sfx_period_timer #(.PERIOD_CLKS(PERIOD_CLKS)) period_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (en),
        .at_zero (period_zero)
    );

    sfx_half_timer #(.HALF_CLKS(HALF_CLKS)) half_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (in_cell),
        .last   (half_last)
    );

    sfx_frame_reg #(.DATA_W(DATA_W)) frame_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .shift     (shift),
        .word      (load_word),
        .cur_bit   (cur_bit),
        .last_cell (cell_last),
        .frame_q   (frame_q)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state;
        if (!en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF, ST_GAP: begin
                    if (period_zero) state_d = ST_HALF1;
                end
                ST_HALF1: begin
                    if (half_last) state_d = ST_HALF2;
                end
                ST_HALF2: begin
                    if (half_last) state_d = cell_last ? ST_GAP : ST_HALF1;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mod_out = 1'b0;
        busy    = 1'b0;
        if (en) begin
            unique case (state)
                ST_HALF1: begin
                    mod_out = cur_bit;
                    busy    = 1'b1;
                end
                ST_HALF2: begin
                    mod_out = ~cur_bit;
                    busy    = 1'b1;
                end
                default: begin
                    mod_out = 1'b0;
                    busy    = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sfx_tx_checker.sv
module sfx_tx_checker #(
    parameter int DATA_W = 10,
    localparam int FRAME_W = sfx_pkg::frame_cells(DATA_W)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               mod_out,
    input logic               busy,
    input logic               start,
    input logic               half_last,
    input logic               period_zero,
    input logic [1:0]         state,
    input logic [FRAME_W-1:0] frame_q
);
    AST_PREAMBLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (frame_q[1:0] == 2'b00)); // R2

    AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (($countones(frame_q) & 1) == 0)); // R5

    AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && en && !half_last) |=> (!en || $stable(mod_out))); // R3

    AST_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        mod_out |-> busy); // R3

    AST_START_ON_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(period_zero)); // R7

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == 2'd0)); // R10

endmodule

bind sensor_frame_tx sfx_tx_checker #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .mod_out     (mod_out),
    .busy        (busy),
    .start       (start),
    .half_last   (half_last),
    .period_zero (period_zero),
    .state       (state),
    .frame_q     (frame_q)
);

// File: tb/sensor_frame_tx_tb_top.sv
module sensor_frame_tx_tb_top;
    localparam int DW = 10;
    localparam int H  = 4;
    localparam int P  = 140;
    localparam int FRAME_CLKS = 26 * H;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [DW-1:0] sample_data = '0;
    logic          sample_valid = 1'b0;
    logic          mod_out;
    logic          busy;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    sensor_frame_tx #(.DATA_W(DW), .HALF_CLKS(H), .PERIOD_CLKS(P)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .sample_data  (sample_data),
        .sample_valid (sample_valid),
        .mod_out      (mod_out),
        .busy         (busy)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%b exp=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Cell value from the requirements: 2 zero cells, data LSB first, even parity
    function automatic logic cell_val(input logic [DW-1:0] w, input int k);
        if (k < 2) return 1'b0;
        if (k < 2 + DW) return w[k-2];
        return ^w;
    endfunction

    function automatic string cell_tag(input int k);
        if (k < 2) return "R2/R3";
        if (k < 2 + DW) return "R4/R3";
        return "R5/R3";
    endfunction

    // Called at the falling edge of cycle 0 after a frame-start edge.
    // upd_mode: 0 none, 1 strobed update at cycle 40, 2 unstrobed change at cycle 40.
    // abort_at >= 0 drops en at that cycle and returns.
    task automatic check_frame(input logic [DW-1:0] w, input int upd_mode,
                               input logic [DW-1:0] upd_w, input int abort_at,
                               input string tag);
        for (int i = 0; i < P; i++) begin
            if (i < FRAME_CLKS) begin
                int k = i / (2 * H);
                logic hb = ((i / H) % 2) != 0;
                chk({cell_tag(k), " ", tag}, $sformatf("mod_out cyc=%0d", i), mod_out, cell_val(w, k) ^ hb);
                chk({"R6 ", tag}, $sformatf("busy cyc=%0d", i), busy, 1'b1);
            end else begin
                chk({"R7 ", tag}, $sformatf("gap mod_out cyc=%0d", i), mod_out, 1'b0);
                chk({"R7/R6 ", tag}, $sformatf("gap busy cyc=%0d", i), busy, 1'b0);
            end
            if (i == abort_at) begin
                en = 1'b0;
                #1;
                chk("R10", "mod_out on disable", mod_out, 1'b0);
                chk("R10", "busy on disable", busy, 1'b0);
                return;
            end
            if (i == 40 && upd_mode != 0) begin
                sample_data  = upd_w;
                sample_valid = (upd_mode == 1);
            end
            if (i == 41) sample_valid = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic check_idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            chk(tag, "idle mod_out", mod_out, 1'b0);
            chk(tag, "idle busy", busy, 1'b0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        en = 1'b1;  // R1: outputs stay idle under reset even with en high
        check_idle(5, "R1");
        en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_idle(3, "R1");
    endtask

    task automatic t_reset_word();
        en = 1'b1;
        @(negedge clk);
        check_frame('0, 0, '0, -1, "R1 word");
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_stream();
        sample_data  = 10'h001;
        sample_valid = 1'b1;   // R8: captured while disabled
        @(negedge clk);
        sample_valid = 1'b0;
        check_idle(4, "R10");
        en = 1'b1;
        @(negedge clk);
        check_frame(10'h001, 1, 10'h2A5, -1, "R9 strobe mid-frame");
        check_frame(10'h2A5, 2, 10'h3FF, -1, "R9 R7 next period");
        check_frame(10'h2A5, 1, 10'h3FF, -1, "R8 unstrobed ignored");
        check_frame(10'h3FF, 0, '0, -1, "R8 strobed");
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_bypass();
        en           = 1'b1;
        sample_data  = 10'h155;
        sample_valid = 1'b1;   // strobe on the frame-start edge
        @(negedge clk);
        sample_valid = 1'b0;
        check_frame(10'h155, 0, '0, -1, "R8 strobe at start");
    endtask

    task automatic t_disable();
        check_frame(10'h155, 0, '0, 30, "R10 abort");
        @(negedge clk);
        check_idle(20, "R10");
        en = 1'b1;
        @(negedge clk);
        check_frame(10'h155, 0, '0, -1, "R10 restart");
        check_frame(10'h155, 0, '0, -1, "R7 repeat");
        en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_reset_word();
        t_stream();
        t_bypass();
        t_disable();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule